// File: doc/BRIEF.md
# Memory Supply Switch Sequencer

This block moves the supply of on-chip memory arrays between the core rail and the memory rail. A client raises a one-cycle request with a target rail. The sequencer then carries out the whole handshake on its own, and reports the result with a one-cycle done pulse. An error flag goes with that pulse when the switch timed out.

On older silicon revisions, the handshake has extra steps around the switch itself. First it quiets six power-manager event lines. Then it parks the CPU and fabric clocks on a safe source by writing the top-level clock mux and two PLL controls. After that comes the switch itself: the sequencer writes the array-mux mode register and polls the array-mux status until it sees the completion code or runs out of samples. Finally it restores the clocks and the events. The order of that restore depends on the direction of the switch. From the threshold revision upward, the event and clock steps are skipped and only the mode write and the poll remain.

All register writes leave through one strobe port: a valid bit, a 2-bit target select and an 8-bit data byte. All delays are cycle counts derived from a clock-frequency parameter.

Top module: `mem_rail_switch_seq`

## Requirements
- R1: After reset, busy, done, err and wr_valid are 0, all six event outputs are 1, and cur_rail is 0 (core rail).
- R2: req_target 2'b01 selects the core rail and 2'b10 the memory rail. Any other value on a request gives a one-cycle err pulse in the next cycle, with no done pulse, no busy and no write.
- R3: Below the revision threshold, the six events drop to 0 together. Exactly 2 us later the clock mux (wr_sel 0) receives 0x13. 200 ns after that, PLL control 0 (wr_sel 1) receives 0xB0, and another 200 ns later PLL control 1 (wr_sel 2) receives 0xB0.
- R4: The mode write (wr_sel 3) carries 0x00 for the memory rail and 0x10 for the core rail. On older revisions it follows the last parking write.
- R5: Completion is status bits [3:0] equal to 0x0 (memory rail) or 0x3 (core rail); the upper status bits are ignored. The first sample is taken in the cycle the mode strobe is visible, and further samples follow every 1 us, up to 10 samples in all.
- R6: After a switch to the memory rail, the restore runs in this order: 0x03 to the clock mux, then 0x30 to PLL control 0, then 0x30 to PLL control 1, with 200 ns between writes. The events rise 1 cycle after the last of those writes.
- R7: After a switch to the core rail, the events rise first. The clock restore (0x03, 0x30, 0x30 at 200 ns spacing) starts 1 cycle later.
- R8: With revision at or above 0x10020000, the events stay at 1 and the mode write is the only write.
- R9: When none of the 10 samples matches, done and err pulse together, the restore steps are still carried out, and cur_rail keeps its value. In bypass mode, done comes exactly 9 us plus 2 cycles after the mode strobe.
- R10: cur_rail (0 core, 1 memory) changes only on a done pulse without err, and it then equals the requested rail.
- R11: A request that arrives while busy is ignored. It adds no write and no second done, and it does not change the result of the switch in progress.
- R12: done is a one-cycle pulse in the same cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle switch request |
| req_target | input | 2 | Requested rail: 01 core, 10 memory |
| revision | input | 32 | Silicon revision value compared against the bypass threshold |
| mux_status | input | STAT_W | Array-mux status; low 4 bits hold the completion code |
| busy | output | 1 | High while a switch sequence runs |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Error flag: with done on timeout, alone on a rejected target |
| cur_rail | output | 1 | Rail last switched to successfully: 0 core, 1 memory |
| wr_valid | output | 1 | Register-write strobe |
| wr_sel | output | 2 | Write target: 0 clock mux, 1 PLL ctl 0, 2 PLL ctl 1, 3 array-mux mode |
| wr_data | output | 8 | Write data byte |
| pm_event | output | N_EVT | Power-manager event lines |

## Verification
The embedded assertions check on every cycle the properties that hold at each edge. Done is a single pulse that coincides with busy falling. The rail record moves only on a successful done. A rejected target produces neither busy nor a write. The poll count never passes its limit. The event lines only ever change as a group, and they stay high whenever a bypassed sequence runs. What no single-cycle property can show is covered by the bench scenarios: the exact order and data of the parking and restore writes in each direction, the spacing measured in cycles between them and relative to the event edges, the exact timeout latency, the masking of the upper status bits, and the fact that a request made mid-sequence leaves no trace.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_EVCLR, S_PARK_MUX, S_PARK_P0, S_PARK_P1, S_MODE, S_POLL,
    S_RST_MUX, S_RST_P0, S_RST_P1, S_EVSET, S_FINISH, S_GAP
  } seq_state_t;

  localparam logic [1:0] TGT_CORE = 2'b01;
  localparam logic [1:0] TGT_MEM  = 2'b10;

  localparam logic [1:0] SEL_CMUX = 2'd0;
  localparam logic [1:0] SEL_PLL0 = 2'd1;
  localparam logic [1:0] SEL_PLL1 = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  localparam logic [7:0] CMUX_PARK   = 8'h13;
  localparam logic [7:0] CMUX_NORMAL = 8'h03;
  localparam logic [7:0] PLL_PARK    = 8'hB0;
  localparam logic [7:0] PLL_NORMAL  = 8'h30;
  localparam logic [7:0] MODE_MEM    = 8'h00;
  localparam logic [7:0] MODE_CORE   = 8'h10;

  localparam logic [3:0] CODE_MEM_DONE  = 4'h0;
  localparam logic [3:0] CODE_CORE_DONE = 4'h3;

endpackage

// File: rtl/mrs_timer.sv
module mrs_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero); // R3

endmodule

// File: rtl/mrs_event_bank.sv
module mrs_event_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         set,
  output logic [N-1:0] ev
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic ev_q;
    always_ff @(posedge clk) begin
      if (rst)      ev_q <= 1'b1;
      else if (clr) ev_q <= 1'b0;
      else if (set) ev_q <= 1'b1;
    end
    assign ev[i] = ev_q;
  end

  AST_EVT_CMD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(clr && set)); // R3
  AST_EVT_GROUPED: assert property (@(posedge clk) disable iff (rst)
    (ev == '0) || (ev == '1)); // R3

endmodule

// File: rtl/mrs_status_match.sv
module mrs_status_match #(
  parameter int STAT_W = 8
) (
  input  logic [STAT_W-1:0] status,
  input  logic              to_mem,
  output logic              match
);
  import mrs_pkg::*;

  logic [3:0] want;
  assign want  = to_mem ? CODE_MEM_DONE : CODE_CORE_DONE;
  assign match = (status[3:0] == want);

endmodule

// File: rtl/mem_rail_switch_seq.sv
module mem_rail_switch_seq #(
  parameter int          CLK_MHZ     = 200,
  parameter int          EVT_WAIT_NS = 2000,
  parameter int          CLK_GAP_NS  = 200,
  parameter int          POLL_NS     = 1000,
  parameter int          MAX_POLLS   = 10,
  parameter int          N_EVT       = 6,
  parameter int          STAT_W      = 8,
  parameter logic [31:0] REV_BYPASS  = 32'h1002_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        req_target,
  input  logic [31:0]       revision,
  input  logic [STAT_W-1:0] mux_status,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cur_rail,
  output logic              wr_valid,
  output logic [1:0]        wr_sel,
  output logic [7:0]        wr_data,
  output logic [N_EVT-1:0]  pm_event
);
  import mrs_pkg::*;

  localparam int EVT_CYC  = CLK_MHZ * EVT_WAIT_NS / 1000;
  localparam int GAP_CYC  = CLK_MHZ * CLK_GAP_NS / 1000;
  localparam int POLL_CYC = CLK_MHZ * POLL_NS / 1000;
  localparam int EVT_LD   = (EVT_CYC  > 2) ? EVT_CYC  - 2 : 0;
  localparam int GAP_LD   = (GAP_CYC  > 2) ? GAP_CYC  - 2 : 0;
  localparam int POLL_LD  = (POLL_CYC > 2) ? POLL_CYC - 2 : 0;
  localparam int MAX_LD   = (EVT_LD > POLL_LD) ? ((EVT_LD > GAP_LD) ? EVT_LD : GAP_LD)
                                               : ((POLL_LD > GAP_LD) ? POLL_LD : GAP_LD);
  localparam int TW       = $clog2(MAX_LD + 1) + 1;
  localparam int SW       = $clog2(MAX_POLLS + 1);
  localparam logic [SW-1:0] LAST_POLL = SW'(MAX_POLLS - 1);

  seq_state_t state_q, state_d, ret_q, ret_d;
  logic          to_mem_q, to_mem_d, bypass_q, bypass_d, tout_q, tout_d;
  logic [SW-1:0] samp_q, samp_d;
  logic          wv_d, done_d, err_d;
  logic [1:0]    ws_d;
  logic [7:0]    wd_d;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          ev_clr, ev_set, stat_ok;
  logic          busy_q, done_q, err_q, rail_q, wv_q;
  logic [1:0]    ws_q;
  logic [7:0]    wd_q;

  mrs_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  mrs_event_bank #(.N(N_EVT)) u_events (
    .clk(clk), .rst(rst), .clr(ev_clr), .set(ev_set), .ev(pm_event)
  );

  mrs_status_match #(.STAT_W(STAT_W)) u_match (
    .status(mux_status), .to_mem(to_mem_q), .match(stat_ok)
  );

  // first step once the array-mux poll has ended, success or not
  function automatic seq_state_t after_switch(input logic byp, input logic mem);
    if (byp)      return S_FINISH;
    else if (mem) return S_RST_MUX;
    else          return S_EVSET;
  endfunction

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    to_mem_d = to_mem_q;
    bypass_d = bypass_q;
    tout_d   = tout_q;
    samp_d   = samp_q;
    wv_d     = 1'b0;
    ws_d     = ws_q;
    wd_d     = wd_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ev_clr   = 1'b0;
    ev_set   = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req) begin
          if (req_target == TGT_CORE || req_target == TGT_MEM) begin
            to_mem_d = (req_target == TGT_MEM);
            bypass_d = (revision >= REV_BYPASS);
            tout_d   = 1'b0;
            state_d  = (revision >= REV_BYPASS) ? S_MODE : S_EVCLR;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      S_EVCLR: begin
        ev_clr   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(EVT_LD);
        ret_d    = S_PARK_MUX;
        state_d  = S_GAP;
      end
      S_PARK_MUX: begin
        wv_d = 1'b1; ws_d = SEL_CMUX; wd_d = CMUX_PARK;
        tmr_load = 1'b1; tmr_val = TW'(GAP_LD);
        ret_d = S_PARK_P0; state_d = S_GAP;
      end
      S_PARK_P0: begin
        wv_d = 1'b1; ws_d = SEL_PLL0; wd_d = PLL_PARK;
        tmr_load = 1'b1; tmr_val = TW'(GAP_LD);
        ret_d = S_PARK_P1; state_d = S_GAP;
      end
      S_PARK_P1: begin
        wv_d = 1'b1; ws_d = SEL_PLL1; wd_d = PLL_PARK;
        state_d = S_MODE;
      end
      S_MODE: begin
        wv_d = 1'b1; ws_d = SEL_MODE;
        wd_d = to_mem_q ? MODE_MEM : MODE_CORE;
        samp_d  = '0;
        state_d = S_POLL;
      end
      S_POLL: begin
        if (stat_ok) begin
          state_d = after_switch(bypass_q, to_mem_q);
        end else if (samp_q == LAST_POLL) begin
          tout_d  = 1'b1;
          state_d = after_switch(bypass_q, to_mem_q);
        end else begin
          samp_d   = samp_q + 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(POLL_LD);
          ret_d    = S_POLL;
          state_d  = S_GAP;
        end
      end
      S_RST_MUX: begin
        wv_d = 1'b1; ws_d = SEL_CMUX; wd_d = CMUX_NORMAL;
        tmr_load = 1'b1; tmr_val = TW'(GAP_LD);
        ret_d = S_RST_P0; state_d = S_GAP;
      end
      S_RST_P0: begin
        wv_d = 1'b1; ws_d = SEL_PLL0; wd_d = PLL_NORMAL;
        tmr_load = 1'b1; tmr_val = TW'(GAP_LD);
        ret_d = S_RST_P1; state_d = S_GAP;
      end
      S_RST_P1: begin
        wv_d = 1'b1; ws_d = SEL_PLL1; wd_d = PLL_NORMAL;
        state_d = to_mem_q ? S_EVSET : S_FINISH;
      end
      S_EVSET: begin
        ev_set  = 1'b1;
        state_d = to_mem_q ? S_FINISH : S_RST_MUX;
      end
      S_FINISH: begin
        done_d  = 1'b1;
        err_d   = tout_q;
        state_d = S_IDLE;
      end
      S_GAP: begin
        if (tmr_zero) state_d = ret_q;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      ret_q    <= S_IDLE;
      to_mem_q <= 1'b0;
      bypass_q <= 1'b0;
      tout_q   <= 1'b0;
      samp_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rail_q   <= 1'b0;
      wv_q     <= 1'b0;
      ws_q     <= '0;
      wd_q     <= '0;
    end else begin
      state_q  <= state_d;
      ret_q    <= ret_d;
      to_mem_q <= to_mem_d;
      bypass_q <= bypass_d;
      tout_q   <= tout_d;
      samp_q   <= samp_d;
      busy_q   <= (state_d != S_IDLE);
      done_q   <= done_d;
      err_q    <= err_d;
      wv_q     <= wv_d;
      ws_q     <= ws_d;
      wd_q     <= wd_d;
      if (state_q == S_FINISH && !tout_q) rail_q <= to_mem_q;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign cur_rail = rail_q;
  assign wr_valid = wv_q;
  assign wr_sel   = ws_q;
  assign wr_data  = wd_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R12
  AST_RAIL_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_rail) |-> (done && !err)); // R10
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (err && !done) |-> (!busy && !wr_valid)); // R2
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    samp_q < SW'(MAX_POLLS)); // R5
  AST_WRITE_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy); // R11
  AST_BYPASS_EVENTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && bypass_q) |-> (pm_event == '1)); // R8

endmodule

// File: tb/mem_rail_switch_seq_tb.sv
module mem_rail_switch_seq_tb;

  localparam int US   = 200;
  localparam int GAP  = 40;
  localparam int EVTW = 400;
  localparam logic [31:0] OLD_REV = 32'h1001_0000;
  localparam logic [31:0] NEW_REV = 32'h1002_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  req_target = 2'b00;
  logic [31:0] revision = OLD_REV;
  logic [7:0]  mux_status;
  logic        busy, done, err, cur_rail, wr_valid;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [5:0]  pm_event;

  always #2.5 clk = ~clk;

  mem_rail_switch_seq u_dut (
    .clk(clk), .rst(rst), .req(req), .req_target(req_target),
    .revision(revision), .mux_status(mux_status), .busy(busy), .done(done),
    .err(err), .cur_rail(cur_rail), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .pm_event(pm_event)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // array-mux model: reacts to the mode write after resp_dly cycles
  int         resp_dly = 10;
  logic       model_en = 1'b1;
  logic       pend;
  int         pend_cnt;
  logic [3:0] pend_code;
  always @(posedge clk) begin
    if (rst) begin
      mux_status <= 8'hA3;
      pend <= 1'b0;
      pend_cnt <= 0;
      pend_code <= 4'h3;
    end else if (wr_valid && wr_sel == 2'd3) begin
      mux_status <= 8'hA9;
      pend      <= model_en;
      pend_cnt  <= resp_dly;
      pend_code <= (wr_data == 8'h00) ? 4'h0 : 4'h3;
    end else if (pend) begin
      if (pend_cnt == 0) begin
        mux_status <= {4'hA, pend_code};
        pend <= 1'b0;
      end else begin
        pend_cnt <= pend_cnt - 1;
      end
    end
  end

  // monitor, sampled on the falling edge
  int         nlog = 0;
  logic [1:0] log_sel [32];
  logic [7:0] log_dat [32];
  int         log_cyc [32];
  int         fall_cyc = -1, rise_cyc = -1, done_cyc = -1;
  int         ndone = 0, nreject = 0, nbusy_rise = 0;
  logic       done_err = 1'b0;
  logic [5:0] prev_ev = 6'h3F;
  logic       prev_busy = 1'b0;
  logic       ev_dropped = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid && nlog < 32) begin
        log_sel[nlog] = wr_sel;
        log_dat[nlog] = wr_data;
        log_cyc[nlog] = cyc;
        nlog++;
      end
      if (pm_event == 6'h00 && prev_ev != 6'h00) begin fall_cyc = cyc; ev_dropped = 1'b1; end
      if (pm_event == 6'h3F && prev_ev != 6'h3F) rise_cyc = cyc;
      if (done) begin ndone++; done_cyc = cyc; done_err = err; end
      if (err && !done) nreject++;
      if (busy && !prev_busy) nbusy_rise++;
      prev_ev = pm_event;
      prev_busy = busy;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0; fall_cyc = -1; rise_cyc = -1; done_cyc = -1;
    ndone = 0; nreject = 0; nbusy_rise = 0; ev_dropped = 1'b0;
  endtask

  task automatic issue(input logic [1:0] tgt);
    @(negedge clk);
    req = 1'b1; req_target = tgt;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 8000 && ndone == 0; i++) @(negedge clk);
    check_eq("R12 done pulse seen", ndone, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_write(input string tag, input int idx, input int sel, input int dat);
    check_eq({tag, " sel"}, int'(log_sel[idx]), sel);
    check_eq({tag, " data"}, int'(log_dat[idx]), dat);
  endtask

  task automatic t_reset();
    check_eq("R1 busy", int'(busy), 0);
    check_eq("R1 done", int'(done), 0);
    check_eq("R1 err", int'(err), 0);
    check_eq("R1 wr_valid", int'(wr_valid), 0);
    check_eq("R1 events", int'(pm_event), 6'h3F);
    check_eq("R1 cur_rail", int'(cur_rail), 0);
  endtask

  task automatic t_reject();
    clear_log();
    issue(2'b11);
    issue(2'b00);
    repeat (20) @(negedge clk);
    check_eq("R2 reject pulses", nreject, 2);
    check_eq("R2 no done", ndone, 0);
    check_eq("R2 no busy", nbusy_rise, 0);
    check_eq("R2 no writes", nlog, 0);
    check_eq("R2 rail kept", int'(cur_rail), 0);
  endtask

  task automatic t_to_mem();
    clear_log();
    revision = OLD_REV; model_en = 1'b1; resp_dly = 3 * US;
    issue(2'b10);
    wait_done();
    check_eq("R3 write count", nlog, 7);
    expect_write("R3 park mux", 0, 0, 8'h13);
    expect_write("R3 park pll0", 1, 1, 8'hB0);
    expect_write("R3 park pll1", 2, 2, 8'hB0);
    expect_write("R4 mode mem", 3, 3, 8'h00);
    check_eq("R3 event wait", log_cyc[0] - fall_cyc, EVTW);
    check_eq("R3 pll0 gap", log_cyc[1] - log_cyc[0], GAP);
    check_eq("R3 pll1 gap", log_cyc[2] - log_cyc[1], GAP);
    check_eq("R4 mode after park", int'(log_cyc[3] > log_cyc[2]), 1);
    check_eq("R5 waits for slow status", int'(done_cyc - log_cyc[3] > 3 * US), 1);
    expect_write("R6 restore mux", 4, 0, 8'h03);
    expect_write("R6 restore pll0", 5, 1, 8'h30);
    expect_write("R6 restore pll1", 6, 2, 8'h30);
    check_eq("R6 restore gap0", log_cyc[5] - log_cyc[4], GAP);
    check_eq("R6 restore gap1", log_cyc[6] - log_cyc[5], GAP);
    check_eq("R6 events after clocks", rise_cyc - log_cyc[6], 1);
    check_eq("R10 no err", int'(done_err), 0);
    check_eq("R10 rail mem", int'(cur_rail), 1);
    check_eq("R12 busy low", int'(busy), 0);
  endtask

  task automatic t_to_core();
    clear_log();
    revision = OLD_REV; model_en = 1'b1; resp_dly = 50;
    issue(2'b01);
    wait_done();
    check_eq("R7 write count", nlog, 7);
    expect_write("R4 mode core", 3, 3, 8'h10);
    expect_write("R7 restore mux", 4, 0, 8'h03);
    expect_write("R7 restore pll1", 6, 2, 8'h30);
    check_eq("R7 clocks after events", log_cyc[4] - rise_cyc, 1);
    check_eq("R7 restore gap", log_cyc[6] - log_cyc[5], GAP);
    check_eq("R10 rail core", int'(cur_rail), 0);
    check_eq("R10 no err", int'(done_err), 0);
  endtask

  task automatic t_bypass();
    clear_log();
    revision = NEW_REV; model_en = 1'b1; resp_dly = 10;
    issue(2'b10);
    wait_done();
    check_eq("R8 only mode write", nlog, 1);
    expect_write("R8 mode", 0, 3, 8'h00);
    check_eq("R8 events untouched", int'(ev_dropped), 0);
    check_eq("R8 rail mem", int'(cur_rail), 1);
  endtask

  task automatic t_bypass_timeout();
    clear_log();
    revision = NEW_REV; model_en = 1'b0;
    issue(2'b01);
    wait_done();
    check_eq("R9 err with done", int'(done_err), 1);
    check_eq("R9 latency", done_cyc - log_cyc[0], 9 * US + 2);
    check_eq("R9 rail kept", int'(cur_rail), 1);
    check_eq("R5 single write", nlog, 1);
  endtask

  task automatic t_timeout_restore();
    clear_log();
    revision = OLD_REV; model_en = 1'b0;
    issue(2'b01);
    wait_done();
    check_eq("R9 err", int'(done_err), 1);
    check_eq("R9 restore still runs", nlog, 7);
    expect_write("R9 restore pll1", 6, 2, 8'h30);
    check_eq("R9 events restored", int'(pm_event), 6'h3F);
    check_eq("R9 rail kept", int'(cur_rail), 1);
  endtask

  task automatic t_busy_ignored();
    clear_log();
    revision = OLD_REV; model_en = 1'b1; resp_dly = 20;
    issue(2'b01);
    repeat (100) @(negedge clk);
    issue(2'b10);
    wait_done();
    repeat (50) @(negedge clk);
    check_eq("R11 one done", ndone, 1);
    check_eq("R11 one busy period", nbusy_rise, 1);
    check_eq("R11 write count", nlog, 7);
    check_eq("R11 first target kept", int'(cur_rail), 0);
    check_eq("R11 idle after", int'(busy), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reject();
    t_to_mem();
    t_to_core();
    t_bypass();
    t_bypass_timeout();
    t_timeout_restore();
    t_busy_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule